// File: doc/BRIEF.md
# Calendar Clock With Periodic Interrupts

This block keeps wall-clock time and a calendar in BCD counters. The counters are milliseconds, hundredths, tenths, seconds, minutes, hours, day of week, day of month and month. A reference tick input advances a small phase divider. Every `SUB_DIV` reference ticks the millisecond counter steps once, and carries ripple up the chain in that same cycle. Software reaches every register through an 8-bit read/write port. A write to any time field restarts the divider phase, so the value just written lasts a full millisecond.

Seven periodic events come from the carry chain: ten per second, and once per second, minute, hour, day, week and month. Together with an alarm, they set bits in a pending-status register. The alarm fires when seconds through month all equal a programmed set of alarm registers. Reading the status register returns the pending bits and clears them. Software is expected to read it only after the interrupt has been raised, and not to poll it. An enable register masks which pending bits drive the single interrupt line.

Top module: `cal_clock_top`

## Requirements
- R1: After reset, milliseconds, hundredths, tenths, seconds, minutes and hours read 0x00. Day of week, day of month and month read 0x01. Status and enable read 0x00, every alarm register reads 0xFF, and `irq` is low.
- R2: The millisecond counter advances once for every `SUB_DIV` reference ticks. Milliseconds, hundredths and tenths each count 0 to 9 and wrap to 0, and each wrap carries into the next field.
- R3: Seconds and minutes wrap from 0x59 to 0x00, and hours wrap from 0x23 to 0x00, each carrying into the next field.
- R4: An hours wrap advances day of week and day of month together. Day of week wraps from 0x07 to 0x01, and month wraps from 0x12 to 0x01.
- R5: Day of month wraps to 0x01 after 0x28 in February, after 0x30 in April, June, September and November, and after 0x31 in every other month. The wrap carries into month.
- R6: Register addresses are as follows. 0x00 to 0x08 hold milliseconds, hundredths, tenths, seconds, minutes, hours, day of week, day of month and month. 0x09 to 0x0E hold the alarm values for seconds, minutes, hours, day of week, day of month and month. 0x10 is status and 0x11 is enable. `bus_rdata` shows the addressed register in the same cycle.
- R7: A write to any time field (0x00 to 0x08) restarts the divider phase. The next millisecond step comes `SUB_DIV` reference ticks after the write.
- R8: Status bits, from bit 0 upward, are: tenths carry (ten per second), second, minute, hour, day, week, month and alarm (bit 7). A bit is set when its event occurs and stays set until status is read. The week bit is set only when day of week wraps.
- R9: A read of status (`bus_rd` at 0x10) returns the pending bits and clears them. An event that occurs in the same cycle as the read stays pending for the next read.
- R10: `irq` is high exactly when some status bit is set whose enable bit is also set. A pending bit whose enable bit is clear does not raise `irq`.
- R11: The alarm bit is set once, in the cycle after seconds through month first all equal the alarm registers. It is not set again while that match persists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference tick; `SUB_DIV` ticks make one millisecond |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read strobe; clears status when addressed |
| bus_rdata | output | 8 | Contents of the addressed register |
| irq | output | 1 | Interrupt request, OR of enabled pending bits |

## Verification
The in-line assertions check, on every cycle, the local rules of the chain and status logic. These are the wraps of milliseconds, hours and day of month when a carry arrives. They also cover the lost divider phase after a time write, sticky accumulation and clear-with-hold of status, and the nesting of a second carry inside a tenths carry. They also check that the alarm pulses once per match onset and that `irq` drops after a read that coincides with no event. Other properties are visible only through the bench scenarios, which drive the block only through its ports. These are full cascades across day, week, month and year-end boundaries, the month-length table, the exact status codes that software reads back, and the gating by the enable mask. They also include the same-cycle race between a read and a new event.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int AW    = 5;
  localparam int DW    = 8;
  localparam int NFLD  = 9;
  localparam int NALM  = 6;
  localparam int NEV   = 8;

  localparam int F_MS  = 0;
  localparam int F_HUN = 1;
  localparam int F_TEN = 2;
  localparam int F_SEC = 3;
  localparam int F_MIN = 4;
  localparam int F_HR  = 5;
  localparam int F_DOW = 6;
  localparam int F_DOM = 7;
  localparam int F_MON = 8;

  localparam logic [AW-1:0] A_NFLD  = AW'(NFLD);
  localparam logic [AW-1:0] A_ALM0  = 5'h09;
  localparam logic [AW-1:0] A_ALMN  = 5'h0F;
  localparam logic [AW-1:0] A_STAT  = 5'h10;
  localparam logic [AW-1:0] A_IEN   = 5'h11;

  // BCD increment of a two-digit value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of a BCD month, February fixed at 28
  function automatic logic [7:0] month_len(input logic [7:0] m);
    case (m)
      8'h02:                      return 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // highest legal value of a field
  function automatic logic [7:0] fld_max(input int idx, input logic [7:0] mon);
    case (idx)
      F_MS, F_HUN, F_TEN: return 8'h09;
      F_SEC, F_MIN:       return 8'h59;
      F_HR:               return 8'h23;
      F_DOW:              return 8'h07;
      F_DOM:              return month_len(mon);
      default:            return 8'h12;
    endcase
  endfunction

  // value a field wraps to (and resets to)
  function automatic logic [7:0] fld_min(input int idx);
    return (idx >= F_DOW) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/cal_chain.sv
module cal_chain
  import cal_pkg::*;
#(
  parameter int SUB_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_tick,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [NFLD*8-1:0]   time_flat,
  output logic [6:0]          rate_ev
);
  localparam int SW = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(SUB_DIV - 1);

  logic [SW-1:0]    sub_q;
  logic             time_wr;
  logic             ms_step;
  logic [NFLD-1:0]  cin;
  logic [NFLD-2:0]  cout;
  logic [7:0]       mon_v;

  assign time_wr = wr_en && (addr < A_NFLD);
  assign ms_step = ref_tick && !time_wr && (sub_q == SUB_LAST);
  assign mon_v   = time_flat[F_MON*8 +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sub_q <= '0;
    else if (time_wr)  sub_q <= '0;
    else if (ref_tick) sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + SW'(1);
  end

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    logic [7:0] val_q;
    logic [7:0] lim;
    assign lim = fld_max(i, mon_v);

    if (i == 0) begin : g_src
      assign cin[i] = ms_step;
    end else if (i == F_DOM) begin : g_src
      assign cin[i] = cout[F_HR];
    end else begin : g_src
      assign cin[i] = cout[i-1];
    end

    if (i < NFLD - 1) begin : g_co
      assign cout[i] = cin[i] && (val_q >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        val_q <= fld_min(i);
      else if (wr_en && addr == AW'(i))  val_q <= wdata;
      else if (cin[i])                   val_q <= (val_q >= lim) ? fld_min(i) : bcd_inc(val_q);
    end

    assign time_flat[i*8 +: 8] = val_q;
  end

  // tenths, second, minute, hour, day, week, month
  assign rate_ev = cout[7:1];

  if (SUB_DIV > 1) begin : g_phase_chk
    p_phase_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      time_wr |=> !ms_step);
  end

  p_ms_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_step && time_flat[7:0] == 8'h09) |=> time_flat[7:0] == 8'h00);

  p_hour_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cin[F_HR] && time_flat[F_HR*8 +: 8] == 8'h23) |=> time_flat[F_HR*8 +: 8] == 8'h00);

  p_dom_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cin[F_DOM] && time_flat[F_DOM*8 +: 8] == month_len(mon_v)) |=> time_flat[F_DOM*8 +: 8] == 8'h01);
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic [NALM*8-1:0]  cmp_time,
  output logic [NALM*8-1:0]  alm_flat,
  output logic               alarm_ev
);
  logic hit, hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_flat <= '1;
    end else if (wr_en) begin
      for (int j = 0; j < NALM; j++)
        if (addr == A_ALM0 + AW'(j)) alm_flat[j*8 +: 8] <= wdata;
    end
  end

  assign hit = (alm_flat == cmp_time);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit;
  end

  assign alarm_ev = hit && !hit_q;

  p_alarm_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_ev |=> !alarm_ev);
endmodule

// File: rtl/cal_irq.sv
module cal_irq
  import cal_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev,
  input  logic           stat_rd,
  input  logic           ien_wr,
  input  logic [DW-1:0]  wdata,
  output logic [NEV-1:0] status_q,
  output logic [NEV-1:0] ien_q,
  output logic           irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= '0;
    else if (stat_rd) status_q <= ev;
    else              status_q <= status_q | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_wr) ien_q <= wdata;
  end

  assign irq = |(status_q & ien_q);

  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> status_q == $past(ev));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> (status_q & $past(status_q)) == $past(status_q));
endmodule

// File: rtl/cal_clock_top.sv
module cal_clock_top
  import cal_pkg::*;
#(
  parameter int SUB_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic [4:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [7:0]    bus_rdata,
  output logic          irq
);
  logic [NFLD*8-1:0] time_flat;
  logic [NALM*8-1:0] alm_flat;
  logic [6:0]        rate_ev;
  logic              alarm_ev;
  logic [NEV-1:0]    ev;
  logic [NEV-1:0]    status_q, ien_q;
  logic              stat_rd;

  assign ev      = {alarm_ev, rate_ev};
  assign stat_rd = bus_rd && (bus_addr == A_STAT);

  cal_chain #(.SUB_DIV(SUB_DIV)) u_chain (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .time_flat(time_flat), .rate_ev(rate_ev)
  );

  cal_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cmp_time(time_flat[F_SEC*8 +: NALM*8]), .alm_flat(alm_flat), .alarm_ev(alarm_ev)
  );

  cal_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .stat_rd(stat_rd),
    .ien_wr(bus_wr && bus_addr == A_IEN), .wdata(bus_wdata),
    .status_q(status_q), .ien_q(ien_q), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < A_NFLD)
      bus_rdata = time_flat[int'(bus_addr)*8 +: 8];
    else if (bus_addr >= A_ALM0 && bus_addr < A_ALMN)
      bus_rdata = alm_flat[int'(bus_addr - A_ALM0)*8 +: 8];
    else if (bus_addr == A_STAT)
      bus_rdata = status_q;
    else if (bus_addr == A_IEN)
      bus_rdata = ien_q;
  end

  p_carry_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rate_ev[1] |-> rate_ev[0]);

  p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ev == '0) |=> !irq);
endmodule

// File: tb/cal_clock_top_tb.sv
module cal_clock_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  cal_clock_top #(.SUB_DIV(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: pops expected read data and compares away from the edge
  always @(negedge clk) begin
    #2;
    if (bus_rd) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: addr %h got %h expected %h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string t, input bit tk = 1'b0);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1; ref_tick = tk;
    @(negedge clk);
    bus_rd = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    ref_tick = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    #2;
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  // field order: month, dom, dow, hour, min, sec, tenths, hundredths, ms
  task automatic set_time(input logic [7:0] mo, dm, dw, hr, mi, se, te, hu, ms);
    wr(5'h08, mo); wr(5'h07, dm); wr(5'h06, dw); wr(5'h05, hr);
    wr(5'h04, mi); wr(5'h03, se); wr(5'h02, te); wr(5'h01, hu); wr(5'h00, ms);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    for (int a = 0; a < 9; a++)
      rd(5'(a), (a >= 6) ? 8'h01 : 8'h00, "R1 time field reset");
    rd(5'h10, 8'h00, "R1 status reset");
    rd(5'h11, 8'h00, "R1 enable reset");
    rd(5'h09, 8'hFF, "R1 alarm reset");
    rd(5'h0E, 8'hFF, "R1 alarm month reset");

    // R2 / R7: one tick advances phase, a write restarts it
    tick(1);
    rd(5'h00, 8'h00, "R2 ms after one tick");
    wr(5'h00, 8'h05);
    tick(1);
    rd(5'h00, 8'h05, "R7 phase restart after write");
    tick(1);
    rd(5'h00, 8'h06, "R2 ms step after SUB_DIV ticks");

    // R2 R3 R4: full cascade, Feb 28 -> Mar 1, dow 7 -> 1
    set_time(8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59, 8'h09, 8'h09, 8'h09);
    tick(2);
    rd(5'h00, 8'h00, "R2 ms wrap");
    rd(5'h01, 8'h00, "R2 hundredths wrap");
    rd(5'h02, 8'h00, "R2 tenths wrap");
    rd(5'h03, 8'h00, "R3 seconds wrap");
    rd(5'h04, 8'h00, "R3 minutes wrap");
    rd(5'h05, 8'h00, "R3 hours wrap");
    rd(5'h06, 8'h01, "R4 day of week wrap");
    rd(5'h07, 8'h01, "R5 February day wrap");
    rd(5'h08, 8'h03, "R5 month advance");
    rd(5'h10, 8'h7F, "R8 all rate bits");
    rd(5'h10, 8'h00, "R9 status cleared");

    // R5 month lengths and R4 year-end month wrap
    set_time(8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59, 8'h09, 8'h09, 8'h09);
    tick(2);
    rd(5'h07, 8'h01, "R5 April 30 wrap");
    rd(5'h08, 8'h05, "R5 April to May");
    rd(5'h06, 8'h02, "R4 dow advance");
    set_time(8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59, 8'h09, 8'h09, 8'h09);
    tick(2);
    rd(5'h07, 8'h31, "R5 January has 31");
    set_time(8'h12, 8'h31, 8'h01, 8'h23, 8'h59, 8'h59, 8'h09, 8'h09, 8'h09);
    tick(2);
    rd(5'h08, 8'h01, "R4 December wraps to 1");
    rd(5'h07, 8'h01, "R5 December 31 wrap");
    rd(5'h10, 8'h5F, "R8 no week bit without dow wrap");

    // R10 enable gating
    wr(5'h11, 8'h02);
    set_time(8'h05, 8'h10, 8'h03, 8'h12, 8'h30, 8'h44, 8'h00, 8'h09, 8'h09);
    tick(2);
    chk_irq(1'b0, "R10 disabled tenths bit keeps irq low");
    rd(5'h10, 8'h01, "R8 tenths only");
    set_time(8'h05, 8'h10, 8'h03, 8'h12, 8'h30, 8'h44, 8'h09, 8'h09, 8'h09);
    tick(2);
    chk_irq(1'b1, "R10 enabled second bit raises irq");
    rd(5'h10, 8'h03, "R8 tenths and second");
    chk_irq(1'b0, "R9 irq drops after read");

    // R9 event in the same cycle as the status read
    set_time(8'h05, 8'h10, 8'h03, 8'h12, 8'h30, 8'h44, 8'h00, 8'h09, 8'h09);
    tick(1);
    rd(5'h10, 8'h00, "R9 read coinciding with event", 1'b1);
    rd(5'h10, 8'h01, "R9 event held for next read");

    // R11 alarm
    wr(5'h11, 8'h80);
    wr(5'h09, 8'h45); wr(5'h0A, 8'h30); wr(5'h0B, 8'h12);
    wr(5'h0C, 8'h03); wr(5'h0D, 8'h10); wr(5'h0E, 8'h05);
    set_time(8'h05, 8'h10, 8'h03, 8'h12, 8'h30, 8'h44, 8'h09, 8'h09, 8'h09);
    chk_irq(1'b0, "R11 no alarm before match");
    tick(2);
    chk_irq(1'b1, "R11 alarm raises irq");
    rd(5'h10, 8'h83, "R11 alarm plus rate bits");
    chk_irq(1'b0, "R11 irq low after read");
    repeat (4) @(negedge clk);
    rd(5'h10, 8'h00, "R11 no refire while matching");

    // R6 register map readback
    rd(5'h0E, 8'h05, "R6 alarm month readback");
    rd(5'h0B, 8'h12, "R6 alarm hour readback");
    rd(5'h11, 8'h80, "R6 enable readback");
    rd(5'h05, 8'h12, "R6 hour readback");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R6: %0d reads not observed, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule